// File: doc/BRIEF.md
# Vertical sync and field parity detector

This block watches a sliced, active-low composite sync line and finds the field-sync interval in it. It measures the low time of every sync pulse in clock cycles. A pulse whose low time reaches a width threshold is taken as a broad field pulse. Shorter pulses, whether line sync or equalising pulses, never start a vertical pulse. The rising edge that ends the first broad pulse starts an active-low vertical pulse. The pulse ends once a set number of narrow equalising pulses has followed the last broad pulse. A timeout ends it if those pulses never come.

The field parity output is decided when the vertical pulse starts. The block compares the start of the triggering low period with a one-cycle line-start strobe. If the broad group began near a line boundary, the field is odd. If it began near mid-line, the field is even.

Some signals hold sync low through the whole field interval with no serrations. For these, the block produces the vertical pulse a fixed delay after the long low period began. A lockout counted in lines stops a second trigger within the same field. All timing comes from parameters, so the same logic serves 625-line and 525-line systems at any sampling clock.

Top module: `vsync_field_det`

## Requirements
- R1: While rst_ni is low, vsync_no is 1 (inactive) and odd_field_o is 0.
- R2: A low pulse on csync_ni (0 = sync) that lasts fewer than BROAD_MIN (default 20) sampled cycles never starts a vertical pulse.
- R3: Let edge n be the first clock edge that samples csync_ni high after a low run of at least BROAD_MIN samples, while the block is idle. Then vsync_no is 0 after edge n+1. Later broad pulses of the same group do not restart the pulse.
- R4: While vsync_no is low, a low pulse counts as equalising when it lasts 1 to EQ_MAX (default 3) samples. A broad pulse clears the count. Let edge n be the edge that samples the end of the EQ_END-th (default 2) equalising pulse after the last broad pulse. Then vsync_no is back to 1 after edge n+1. Pulses wider than EQ_MAX but shorter than BROAD_MIN do not count.
- R5: vsync_no is never low for more than VS_MAX (default 512) consecutive cycles. If no equalising pulses arrive, it is low for exactly VS_MAX cycles.
- R6: Suppose the block is idle, edge n is the first edge to sample csync_ni low, and the line stays low. Then vsync_no is 0 after edge n+DEFAULT_DLY+1 (default DEFAULT_DLY is 48).
- R7: Let the last href_i strobe be sampled at edge h, and let the triggering low period be first sampled low at edge h+d. On the edge where vsync_no falls, odd_field_o is set as follows:
  - 1 (odd) if d < LINE_CLKS/4 or d >= 3*LINE_CLKS/4;
  - 0 (even) otherwise.
  odd_field_o changes on no other edge.
- R8: After vsync_no returns to 1, no new vertical pulse starts until LOCK_LINES (default 8) href_i strobes have been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csync_ni | input | 1 | Sliced composite sync, 0 = sync tip, synchronous to clk_i |
| href_i | input | 1 | One-cycle strobe at each line start |
| vsync_no | output | 1 | Vertical sync, active low |
| odd_field_o | output | 1 | 1 = odd field, 0 = even field |

## Verification
The vertical pulse starts one edge after the edge that samples the broad pulse's rising edge. It ends one edge after the edge that samples the rise of the closing equalising pulse. In the no-serration case it starts DEFAULT_DLY+1 edges after the first low sample. A timeout ends it exactly VS_MAX cycles after it starts. Parity is valid on the same edge that starts the pulse.

The bench drives one input step per falling clock edge and numbers the steps. It samples both outputs on the falling edge that closes each step, and records the step index at which vsync_no falls or rises. It then compares these indices with values computed from the step index of the stimulus edge plus the latencies above.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VS   = 2'd1,
    ST_LOCK = 2'd2
  } vfd_state_e;
endpackage

// File: rtl/vfd_edge.sv
module vfd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csync_ni,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic c_q, c_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q <= 1'b1;
      c_d <= 1'b1;
    end else begin
      c_q <= csync_ni;
      c_d <= c_q;
    end
  end

  assign level_o = c_q;
  assign rise_o  = c_q & ~c_d;
  assign fall_o  = ~c_q & c_d;
endmodule

// File: rtl/vfd_meas.sv
module vfd_meas #(
  parameter int LCW = 9,
  parameter int PW  = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           level_i,
  input  logic           fall_i,
  input  logic           href_i,
  output logic [LCW-1:0] low_cnt_o,
  output logic [PW-1:0]  start_pos_o
);
  localparam logic [LCW-1:0] LC_MAX = '1;
  localparam logic [PW-1:0]  LP_MAX = '1;

  logic [PW-1:0] line_pos;

  // low run length, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               low_cnt_o <= '0;
    else if (level_i)          low_cnt_o <= '0;
    else if (low_cnt_o != LC_MAX) low_cnt_o <= low_cnt_o + 1'b1;
  end

  // position within the line, restarted by the line strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 line_pos <= '0;
    else if (href_i)             line_pos <= '0;
    else if (line_pos != LP_MAX) line_pos <= line_pos + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     start_pos_o <= '0;
    else if (fall_i) start_pos_o <= line_pos;
  end
endmodule

// File: rtl/vfd_ctrl.sv
module vfd_ctrl
  import vfd_pkg::*;
#(
  parameter int LINE_CLKS   = 64,
  parameter int BROAD_MIN   = 20,
  parameter int EQ_MAX      = 3,
  parameter int EQ_END      = 2,
  parameter int DEFAULT_DLY = 48,
  parameter int VS_MAX      = 512,
  parameter int LOCK_LINES  = 8,
  parameter int LCW         = 9,
  parameter int PW          = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rise_i,
  input  logic           level_i,
  input  logic           href_i,
  input  logic [LCW-1:0] low_cnt_i,
  input  logic [PW-1:0]  start_pos_i,
  output logic           vsync_no,
  output logic           odd_o
);
  localparam int TW  = $clog2(VS_MAX);
  localparam int EQW = $clog2(EQ_END + 1);
  localparam int LKW = $clog2(LOCK_LINES + 1);
  localparam logic [LCW-1:0] BROAD_C = LCW'(BROAD_MIN);
  localparam logic [LCW-1:0] EQMAX_C = LCW'(EQ_MAX);
  localparam logic [LCW-1:0] DLY_C   = LCW'(DEFAULT_DLY);
  localparam logic [PW-1:0]  Q1_C    = PW'(LINE_CLKS / 4);
  localparam logic [PW-1:0]  Q3_C    = PW'(LINE_CLKS - LINE_CLKS / 4);
  localparam logic [TW-1:0]  TMO_C   = TW'(VS_MAX - 1);
  localparam logic [EQW-1:0] EQL_C   = EQW'(EQ_END - 1);
  localparam logic [LKW-1:0] LKL_C   = LKW'(LOCK_LINES - 1);

  vfd_state_e state_q;
  logic [TW-1:0]  tmr_q;
  logic [EQW-1:0] eq_q;
  logic [LKW-1:0] lock_q;

  logic broad, eq_pulse, fb_hit, near_start;
  assign broad      = rise_i && (low_cnt_i >= BROAD_C);
  assign eq_pulse   = rise_i && (low_cnt_i != '0) && (low_cnt_i <= EQMAX_C);
  assign fb_hit     = !level_i && (low_cnt_i == DLY_C);
  assign near_start = (start_pos_i < Q1_C) || (start_pos_i >= Q3_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tmr_q    <= '0;
      eq_q     <= '0;
      lock_q   <= '0;
      vsync_no <= 1'b1;
      odd_o    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (broad || fb_hit) begin
            state_q  <= ST_VS;
            vsync_no <= 1'b0;
            odd_o    <= near_start;
            tmr_q    <= '0;
            eq_q     <= '0;
          end
        end
        ST_VS: begin
          tmr_q <= tmr_q + 1'b1;
          if (broad)         eq_q <= '0;
          else if (eq_pulse) eq_q <= eq_q + 1'b1;
          if ((eq_pulse && eq_q == EQL_C) || tmr_q == TMO_C) begin
            state_q  <= ST_LOCK;
            vsync_no <= 1'b1;
            lock_q   <= '0;
          end
        end
        ST_LOCK: begin
          if (href_i) begin
            if (lock_q == LKL_C) state_q <= ST_IDLE;
            else                 lock_q  <= lock_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vsync_field_det.sv
module vsync_field_det #(
  parameter int LINE_CLKS   = 64,
  parameter int BROAD_MIN   = 20,
  parameter int EQ_MAX      = 3,
  parameter int EQ_END      = 2,
  parameter int DEFAULT_DLY = 48,
  parameter int VS_MAX      = 512,
  parameter int LOCK_LINES  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csync_ni,
  input  logic href_i,
  output logic vsync_no,
  output logic odd_field_o
);
  localparam int LCW = $clog2(4 * LINE_CLKS + 1);
  localparam int PW  = $clog2(2 * LINE_CLKS);

  logic           edge_level, edge_rise, edge_fall;
  logic [LCW-1:0] low_cnt;
  logic [PW-1:0]  start_pos;

  vfd_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .csync_ni (csync_ni),
    .level_o  (edge_level),
    .rise_o   (edge_rise),
    .fall_o   (edge_fall)
  );

  vfd_meas #(.LCW(LCW), .PW(PW)) u_meas (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .level_i     (edge_level),
    .fall_i      (edge_fall),
    .href_i      (href_i),
    .low_cnt_o   (low_cnt),
    .start_pos_o (start_pos)
  );

  vfd_ctrl #(
    .LINE_CLKS   (LINE_CLKS),
    .BROAD_MIN   (BROAD_MIN),
    .EQ_MAX      (EQ_MAX),
    .EQ_END      (EQ_END),
    .DEFAULT_DLY (DEFAULT_DLY),
    .VS_MAX      (VS_MAX),
    .LOCK_LINES  (LOCK_LINES),
    .LCW         (LCW),
    .PW          (PW)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (edge_rise),
    .level_i     (edge_level),
    .href_i      (href_i),
    .low_cnt_i   (low_cnt),
    .start_pos_i (start_pos),
    .vsync_no    (vsync_no),
    .odd_o       (odd_field_o)
  );
endmodule

// File: rtl/vfd_chk.sv
module vfd_chk #(
  parameter int BROAD_MIN   = 20,
  parameter int EQ_MAX      = 3,
  parameter int DEFAULT_DLY = 48,
  parameter int VS_MAX      = 512,
  parameter int LOCK_LINES  = 8,
  parameter int LCW         = 9
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           href_i,
  input logic           vsync_no,
  input logic           odd_field_o,
  input logic           rise_i,
  input logic           level_i,
  input logic [LCW-1:0] low_cnt_i
);
  localparam int RW  = $clog2(VS_MAX + 2);
  localparam int LNW = $clog2(LOCK_LINES + 2);
  localparam logic [LCW-1:0] BROAD_C = LCW'(BROAD_MIN);
  localparam logic [LCW-1:0] EQMAX_C = LCW'(EQ_MAX);
  localparam logic [LCW-1:0] DLY_C   = LCW'(DEFAULT_DLY);
  localparam logic [RW-1:0]  VSM_C   = RW'(VS_MAX);
  localparam logic [LNW-1:0] LKL_C   = LNW'(LOCK_LINES);
  localparam logic [LNW-1:0] LN_MAX  = '1;

  logic [RW-1:0]  low_run;
  logic [LNW-1:0] lines_since;
  logic           vs_prev, seen_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run     <= '0;
      lines_since <= '0;
      vs_prev     <= 1'b1;
      seen_end    <= 1'b0;
    end else begin
      vs_prev <= vsync_no;
      if (vsync_no) low_run <= '0;
      else if (low_run != '1) low_run <= low_run + 1'b1;
      if (vsync_no && !vs_prev) begin
        seen_end    <= 1'b1;
        lines_since <= href_i ? LNW'(1) : '0;
      end else if (href_i && lines_since != LN_MAX) begin
        lines_since <= lines_since + 1'b1;
      end
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (vsync_no && !odd_field_o)
        else $error("R1 outputs not idle in reset");
    end
  end

  p_short_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_no && rise_i && low_cnt_i < BROAD_C) |=> vsync_no);

  p_start_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vsync_no) |-> ($past(rise_i && low_cnt_i >= BROAD_C) ||
                         $past(!level_i && low_cnt_i == DLY_C)));

  p_end_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_no) |-> ($past(rise_i && low_cnt_i != '0 && low_cnt_i <= EQMAX_C) ||
                         low_run == VSM_C));

  p_max_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_run <= VSM_C);

  p_parity_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(vsync_no) |-> $stable(odd_field_o));

  p_lockout_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_end && $fell(vsync_no)) |-> lines_since >= LKL_C);
endmodule

bind vsync_field_det vfd_chk #(
  .BROAD_MIN   (BROAD_MIN),
  .EQ_MAX      (EQ_MAX),
  .DEFAULT_DLY (DEFAULT_DLY),
  .VS_MAX      (VS_MAX),
  .LOCK_LINES  (LOCK_LINES),
  .LCW         (LCW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .href_i      (href_i),
  .vsync_no    (vsync_no),
  .odd_field_o (odd_field_o),
  .rise_i      (edge_rise),
  .level_i     (edge_level),
  .low_cnt_i   (low_cnt)
);

// File: tb/vsync_field_det_test.sv
module vsync_field_det_test;
  localparam int CLK_PERIOD  = 10;
  localparam int LINE        = 64;
  localparam int HALF        = LINE / 2;
  localparam int BROAD_MIN   = 20;
  localparam int EQ_MAX      = 3;
  localparam int EQ_END      = 2;
  localparam int DEFAULT_DLY = 48;
  localparam int VS_MAX      = 512;
  localparam int LOCK_LINES  = 8;
  localparam int WD_CYCLES   = 150000;
  localparam int SEED        = 24681;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic csync_ni = 1'b1;
  logic href_i = 1'b0;
  logic vsync_no, odd_field_o;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, n_falls = 0, fall_cyc = -1, rise_cyc = -1;
  int fall_odd = 0, hphase = 0;
  logic prev_vs = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vsync_field_det #(
    .LINE_CLKS(LINE), .BROAD_MIN(BROAD_MIN), .EQ_MAX(EQ_MAX), .EQ_END(EQ_END),
    .DEFAULT_DLY(DEFAULT_DLY), .VS_MAX(VS_MAX), .LOCK_LINES(LOCK_LINES)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .csync_ni(csync_ni), .href_i(href_i),
    .vsync_no(vsync_no), .odd_field_o(odd_field_o)
  );

  function automatic int exp_start(int first_high_step);
    return first_high_step + 1;
  endfunction
  function automatic int exp_fallback(int first_low_step);
    return first_low_step + DEFAULT_DLY + 1;
  endfunction
  function automatic int exp_parity(int offset);
    return (offset < LINE / 4 || offset >= LINE - LINE / 4) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one input step; sample at the next falling edge
  task automatic step(input logic c, input logic h);
    csync_ni = c;
    href_i   = h;
    @(negedge clk);
    cyc++;
    if (prev_vs && !vsync_no) begin
      n_falls++;
      fall_cyc = cyc;
      fall_odd = int'(odd_field_o);
    end
    if (!prev_vs && vsync_no) rise_cyc = cyc;
    prev_vs = vsync_no;
  endtask

  task automatic half(input int low_len);
    logic h0;
    h0 = (hphase == 0);
    for (int i = 0; i < HALF; i++) step((i < low_len) ? 1'b0 : 1'b1, (i == 0) && h0);
    hphase ^= 1;
  endtask

  task automatic lines(input int n, input int lw);
    while (hphase != 0) half(0);
    for (int k = 0; k < n; k++) begin
      half(lw);
      half(0);
    end
  endtask

  task automatic field(input int odd, input int bw, input int ew, input int post_eq,
                       output int efall, output int eend);
    int b0, e1;
    while (hphase != ((odd != 0) ? 1 : 0)) half(0);
    repeat (5) half(ew);
    b0 = cyc + 1;
    repeat (5) half(bw);
    efall = exp_start(b0 + bw);
    e1 = cyc + 1;
    repeat (5) half((post_eq != 0) ? ew : 0);
    if (post_eq != 0) eend = exp_start(e1 + (EQ_END - 1) * HALF + ew);
    else              eend = efall + VS_MAX;
  endtask

  task automatic run_field(input int odd, input int bw, input int ew, input int post_eq,
                           input int nl, input int lw);
    int nf0, efall, eend;
    nf0 = n_falls;
    field(odd, bw, ew, post_eq, efall, eend);
    lines(nl, lw);
    chk("R3 one pulse per field", n_falls - nf0, 1);
    chk("R3 start cycle", fall_cyc, efall);
    if (post_eq != 0) chk("R4 end cycle", rise_cyc, eend);
    else              chk("R5 timeout end", rise_cyc, eend);
    chk("R7 parity", fall_odd, odd);
  endtask

  initial begin
    int a, b, c, d, nf0, f0;
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    chk("R1 vsync in reset", int'(vsync_no), 1);
    chk("R1 odd in reset", int'(odd_field_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2: line and equalising pulses, then widths just under the threshold
    lines(12, 5);
    repeat (5) half(2);
    chk("R2 short pulses ignored", n_falls, 0);
    lines(2, BROAD_MIN - 1);
    chk("R2 width BROAD_MIN-1 ignored", n_falls, 0);
    chk("R2 vsync idle", int'(vsync_no), 1);

    run_field(1, 27, 2, 1, 10, 5);
    run_field(0, 27, 2, 1, 10, 5);

    // R8: second broad group inside the lockout window
    nf0 = n_falls;
    field(1, 27, 2, 1, a, b);
    field(0, 27, 2, 1, c, d);
    lines(10, 5);
    chk("R8 lockout blocks retrigger", n_falls - nf0, 1);
    chk("R8 end of first pulse", rise_cyc, b);
    chk("R7 parity held while locked", int'(odd_field_o), 1);

    // R5: no equalising pulses after the broad group
    run_field(0, 27, 2, 0, 20, 5);

    // R6: long low with no serrations, starting at a line start
    while (hphase != 0) half(0);
    nf0 = n_falls;
    f0 = cyc + 1;
    repeat (5) half(HALF);
    lines(20, 5);
    chk("R6 one fallback pulse", n_falls - nf0, 1);
    chk("R6 fallback start", fall_cyc, exp_fallback(f0));
    chk("R7 fallback parity", fall_odd, exp_parity(0));
    chk("R5 fallback timeout", rise_cyc, exp_fallback(f0) + VS_MAX);

    // boundaries: broad exactly BROAD_MIN, equalising exactly EQ_MAX
    run_field(0, BROAD_MIN, 2, 1, 10, 5);
    run_field(1, 26, EQ_MAX, 1, 10, EQ_MAX + 1);

    for (int k = 0; k < 8; k++) begin
      int odd, bw, ew, lw, nl;
      odd = int'($urandom % 2);
      bw  = BROAD_MIN + 2 + int'($urandom % 9);
      ew  = 1 + int'($urandom % EQ_MAX);
      lw  = EQ_MAX + 1 + int'($urandom % 8);
      nl  = 10 + int'($urandom % 4);
      run_field(odd, bw, ew, 1, nl, lw);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule